// File: doc/BRIEF.md
# Priority interrupt concentrator with set/clear masking

The block gathers a bank of level-sensitive peripheral request lines and presents one prioritised request to a processor. Every cycle it looks at every line that is high, not masked and assigned a non-zero priority. It then reports whether any such line exists, the highest priority level among them, and the index of the line that holds that level. These three outputs are registered.

Software configures the block through a plain 32-bit register port: a byte address, a write strobe, write data and combinational read data. Masks change only through two write-one registers, one that masks and one that unmasks, so a single source can be changed without a read-modify-write. Priorities are held in read/write words. Each word packs eight 4-bit fields. Each field is shared by a fixed group of neighbouring sources.

Register groups are selected by address bits [5:4]:

| addr[5:4] | Group |
|---|---|
| 0 | priority |
| 1 | mask-set |
| 2 | mask-clear |
| 3 | unmapped |

Address bits [3:2] select the word within the group. Address bits [1:0] are ignored.

Top module: `intc_setclr`

## Requirements
- R1: After reset every source is masked (mask bit = 1), every priority field is 0, and `irq_o` is 0. A masked source never becomes the reported winner.
- R2: A write to mask-set word w sets mask bit 32*w+b for each 1 in `wdata_i[b]`. Mask bits written with 0 keep their value.
- R3: A write to mask-clear word w clears mask bit 32*w+b for each 1 in `wdata_i[b]`. Bits written with 0 are untouched. With no write to either mask group, the mask does not change.
- R4: Reading a mask-set word returns the 32 mask bits of that word. Reading a mask-clear word, an unmapped group, or a word index beyond the group's size returns 0.
- R5: Priority words are read/write and hold eight 4-bit fields at bits [4k+3:4k]. Source i takes its level from field f = i/4, which is word f/8, bits [4*(f%8)+3 : 4*(f%8)]. Writing one word leaves the other words unchanged.
- R6: `irq_o` is 1, one cycle after the inputs and registers are presented, exactly when some source is high, unmasked and has a non-zero level. A level of 0 never raises a request.
- R7: `level_o` is the highest level among the eligible sources. `id_o` is the lowest index among the sources at that level. Both outputs are 0 when `irq_o` is 0.
- R8: Requests are not latched. One cycle after a line falls, the line no longer contributes to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 96 | Level-sensitive request lines |
| addr_i | input | 6 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Registered request to the processor |
| level_o | output | 4 | Registered winning level |
| id_o | output | 7 | Registered winning source index |

## Verification
The assertions run on every cycle. They check that an idle output carries a zero level and a zero index, and that an active request always has a non-zero level. They check that the reported winner was high and unmasked in the cycle before. They also check that the mask moves only on a mask-group write, that a written set bit sticks, and that the clear group always reads zero. Whether the reported winner is truly the highest and lowest-indexed eligible source can only be shown by the bench's scenarios. The same holds for shared priority fields and for clear writes that leave 0 bits alone. The bench compares these against a reference built from the requirements, over directed tie and boundary cases and random register traffic.

// File: rtl/intc_setclr.sv
module intc_setclr #(
  parameter int N_SRC = 96,
  parameter int SHARE = 4,
  parameter int LVL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         src_i,
  input  logic [5:0]               addr_i,
  input  logic                     we_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic                     irq_o,
  output logic [LVL_W-1:0]         level_o,
  output logic [$clog2(N_SRC)-1:0] id_o
);
  localparam int N_MW  = N_SRC / 32;
  localparam int N_FLD = N_SRC / SHARE;
  localparam int N_PW  = N_FLD / (32 / LVL_W);
  localparam int IDW   = $clog2(N_SRC);

  logic [N_SRC-1:0]     mask_q;
  logic [32*N_PW-1:0]   prio_q;
  logic [1:0]           grp, wsel;
  logic [N_SRC-1:0]     elig;
  logic [LVL_W-1:0]     best_lvl;
  logic [IDW-1:0]       best_id;

  assign grp  = addr_i[5:4];
  assign wsel = addr_i[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      prio_q <= '0;
    end else if (we_i) begin
      case (grp)
        2'd0: if (int'(wsel) < N_PW) prio_q[32*wsel +: 32] <= wdata_i;
        2'd1: if (int'(wsel) < N_MW) mask_q[32*wsel +: 32] <= mask_q[32*wsel +: 32] | wdata_i;
        2'd2: if (int'(wsel) < N_MW) mask_q[32*wsel +: 32] <= mask_q[32*wsel +: 32] & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (grp)
      2'd0: if (int'(wsel) < N_PW) rdata_o = prio_q[32*wsel +: 32];
      2'd1: if (int'(wsel) < N_MW) rdata_o = mask_q[32*wsel +: 32];
      default: ;
    endcase
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = src_i[i] && !mask_q[i] && (prio_q[LVL_W*(i/SHARE) +: LVL_W] != '0);
  end

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && prio_q[LVL_W*(i/SHARE) +: LVL_W] > best_lvl) begin
        best_lvl = prio_q[LVL_W*(i/SHARE) +: LVL_W];
        best_id  = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o   <= 1'b0;
      level_o <= '0;
      id_o    <= '0;
    end else begin
      irq_o   <= |elig;
      level_o <= best_lvl;
      id_o    <= best_id;
    end
  end
endmodule

// File: rtl/intc_setclr_chk.sv
module intc_setclr_chk #(
  parameter int N_SRC = 96,
  parameter int LVL_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         src_i,
  input logic [5:0]               addr_i,
  input logic                     we_i,
  input logic [31:0]              wdata_i,
  input logic [31:0]              rdata_o,
  input logic                     irq_o,
  input logic [LVL_W-1:0]         level_o,
  input logic [$clog2(N_SRC)-1:0] id_o,
  input logic [N_SRC-1:0]         mask_q
);
  logic [N_SRC-1:0] src_d, msk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_d <= '0;
      msk_d <= '1;
    end else begin
      src_d <= src_i;
      msk_d <= mask_q;
    end
  end

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (level_o == '0 && id_o == '0));

  a_r6_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> level_o != '0);

  a_r8_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> src_d[id_o]);

  a_r1_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !msk_d[id_o]);

  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (addr_i[5:4] == 2'd1 || addr_i[5:4] == 2'd2)) |=> $stable(mask_q));

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i[5:2] == 4'b0100) |=> ((mask_q[31:0] & $past(wdata_i)) == $past(wdata_i)));

  a_r4_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[5:4] == 2'd2) |-> rdata_o == '0);
endmodule

bind intc_setclr intc_setclr_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .level_o(level_o),
  .id_o(id_o), .mask_q(mask_q)
);

// File: tb/tb_intc_setclr.sv
module tb_intc_setclr;
  logic        clk = 0, rst_n = 0;
  logic [95:0] src_i = '0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o;
  logic [3:0]  level_o;
  logic [6:0]  id_o;

  int total = 0, bad = 0;
  logic [95:0] m_mask;
  logic [95:0] m_prio;

  intc_setclr dut (.*);

  always #5 clk = ~clk;

  function automatic logic [3:0] lvl_of(int i);
    return m_prio[4*(i/4) +: 4];
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] a);
    int w = a[3:2];
    if (a[5:4] == 2'd0 && w < 3) return m_prio[32*w +: 32];
    if (a[5:4] == 2'd1 && w < 3) return m_mask[32*w +: 32];
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [95:0] s, logic w, logic [5:0] a, logic [31:0] d, string tag);
    logic       e_irq;
    logic [3:0] e_lvl;
    logic [6:0] e_id;
    @(negedge clk);
    src_i = s; we_i = w; addr_i = a; wdata_i = d;
    e_irq = 0; e_lvl = 0; e_id = 0;
    for (int i = 0; i < 96; i++)
      if (s[i] && !m_mask[i] && lvl_of(i) != 0) begin
        e_irq = 1;
        if (lvl_of(i) > e_lvl) begin e_lvl = lvl_of(i); e_id = 7'(i); end
      end
    @(posedge clk); #1;
    we_i = 0;
    chk({tag, " R6 irq"}, 32'(irq_o), 32'(e_irq));
    chk({tag, " R7 level"}, 32'(level_o), 32'(e_lvl));
    chk({tag, " R7 id"}, 32'(id_o), 32'(e_id));
    if (w) begin
      int k = a[3:2];
      if (a[5:4] == 2'd0 && k < 3) m_prio[32*k +: 32] = d;
      if (a[5:4] == 2'd1 && k < 3) m_mask[32*k +: 32] = m_mask[32*k +: 32] | d;
      if (a[5:4] == 2'd2 && k < 3) m_mask[32*k +: 32] = m_mask[32*k +: 32] & ~d;
    end
  endtask

  task automatic rd(logic [5:0] a, string tag);
    @(negedge clk);
    we_i = 0; addr_i = a; #1;
    chk(tag, rdata_o, exp_read(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_mask = '1; m_prio = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 reset irq", 32'(irq_o), 32'd0);
    for (int w = 0; w < 3; w++) begin
      rd(6'(16 + 4*w), "R1 reset mask");
      rd(6'(4*w), "R1 reset prio");
    end
    // R1: masked source with level stays silent
    step(96'h2, 1, 6'h00, 32'h0000_0050, "R1 masked");
    step(96'h2, 0, 6'h00, 0, "R1 masked hold");
    // R3: unmask bits 1..3; field 0 levels from bits [3:0] -> src1..3 use field 0
    step(96'h2, 1, 6'h20, 32'h0000_000E, "R3 clear");
    step(96'h2, 0, 6'h00, 0, "R6 zero level");
    step(96'h2, 1, 6'h00, 32'h0000_0007, "R5 field0");
    step(96'hE, 0, 6'h00, 0, "R7 tie lowest");
    rd(6'h10, "R4 set read");
    rd(6'h20, "R4 clr read");
    rd(6'h30, "R4 unmapped");
    rd(6'h1C, "R4 beyond group");
    // R2: mask src1 again, src2 wins
    step(96'hE, 1, 6'h10, 32'h0000_0002, "R2 set one");
    rd(6'h10, "R2 readback");
    // R3: clear with 0 bits leaves others
    step(96'hE, 1, 6'h20, 32'h0000_0000, "R3 zero clear");
    rd(6'h10, "R3 readback");
    // R5/R7: higher level in word 2 (src 95, field 23 -> word2 bits 31:28)
    step(96'hE, 1, 6'h28, 32'h8000_0000, "R3 clear top");
    step({1'b1, 95'hE}, 1, 6'h08, 32'hC000_0000, "R5 word2");
    step({1'b1, 95'hE}, 0, 6'h00, 0, "R7 highest");
    rd(6'h00, "R5 word0 intact");
    rd(6'h08, "R5 word2 read");
    // R8: drop lines
    step(96'h4, 0, 6'h00, 0, "R8 drop top");
    step(96'h0, 0, 6'h00, 0, "R8 all low");
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [95:0] s;
      logic [5:0]  a;
      s = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      a = 6'({$urandom_range(0, 3), 2'($urandom_range(0, 3)), 2'b00});
      step(s, 1'($urandom_range(0, 1)), a, $urandom, "R7 random");
      if (n % 8 == 0) rd(a, "R4 random read");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule